// File: doc/BRIEF.md
# Split-Mode Auto-Reload Timer

This block is an up-counting timer made of a low byte and a high byte. Each byte has an 8-bit reload register. In 16-bit mode the two bytes form one counter. When the full counter passes 0xFFFF it restarts from the 16-bit reload value. In split mode the bytes are two separate 8-bit counters. Each byte has its own rate select and its own overflow flag, and each restarts from its own reload byte when it wraps.

Software controls the block through a simple write port. The port carries a 3-bit address and an 8-bit data byte, and a write takes effect at the clock edge where the write enable is high. Every count rate is a single-cycle enable pulse in the system clock domain, so the block has no derived clocks. Three rates are available: every cycle, one cycle in twelve, or one pulse per eight falling edges of a slow external clock. The external clock is synchronized and its edges are counted. The two overflow flags are sticky. They drive one level-sensitive interrupt request, and an enable bit decides whether low-byte overflows may raise it. Per-byte overflow strobes are provided for downstream consumers. The port set is control and status only, so it carries no valid/ready handshake and no back-pressure.

Top module: `split_timer`

## Requirements
- R1: In 16-bit mode (split bit = 0) the counter {high,low} steps by one on each low-byte enable. The step after 0xFFFF loads the 16-bit reload value {reload_hi, reload_lo}. A low-byte wrap that is not a full wrap moves the low byte to 0x00 and carries one into the high byte. Only the high flag is set in this mode.
- R2: In split mode (split bit = 1) each byte steps on its own enable. A byte at 0xFF loads its own reload byte on its next step.
- R3: The high flag is set when the high byte (or the full counter in 16-bit mode) wraps. The low flag is set when the low byte wraps in split mode. ovf_hi_o and ovf_lo_o are high in the cycle before such a wrap edge, meaning a step is enabled while the byte is at 0xFF.
- R4: With the interrupt-enable control bit set, irq_o is high while the high flag is set. With that bit clear, irq_o stays low.
- R5: The low flag drives irq_o only when both the interrupt-enable bit and the low-interrupt-enable bit are set.
- R6: Flags are never cleared by hardware. A write to the flag register (address 1) loads data bit 0 into the low flag and data bit 1 into the high flag, so writing 0 clears them.
- R7: When a flag write and a hardware set for the same flag fall in the same cycle, the flag ends up set.
- R8: Rate select, per byte: with its fast bit set the byte steps every cycle. Otherwise it steps once every 12 cycles when the shared external-select bit is 0, and once per 8 falling edges of ext_clk_i when that bit is 1. In 16-bit mode the low byte's select drives the whole counter.
- R9: With the run bit clear the counter holds its value, apart from software writes to it. A control write takes effect at its own edge.
- R10: Write addresses: 0 = control, 1 = flags, 2 = counter low, 3 = counter high, 4 = reload low, 5 = reload high. The control bits are bit0 run, bit1 split, bit2 low-interrupt enable, bit3 interrupt enable, bit4 external select, bit5 low fast, bit6 high fast. A software write to a counter byte overrides counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; counter, reloads, control and flags go to zero |
| ext_clk_i | input | 1 | Slow external clock, sampled and synchronized |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| cnt_o | output | 16 | Current counter value {high, low} |
| ovf_lo_o | output | 1 | Low byte wraps at the next edge |
| ovf_hi_o | output | 1 | High byte (or full counter) wraps at the next edge |
| flag_lo_o | output | 1 | Sticky low-byte overflow flag |
| flag_hi_o | output | 1 | Sticky high-byte overflow flag |
| irq_o | output | 1 | Combined interrupt request (level) |

## Verification
A wrong reload or carry path shows on cnt_o at the first edge after a wrap. That is within one enabled step of the byte reaching 0xFF. A broken flag path shows on flag_lo_o, flag_hi_o and irq_o in the same cycle the counter reloads, and a lost sticky flag shows in the cycle after it drops. Rate-select faults only appear as a wrong count delta over a window. The bench therefore measures 120-cycle and 800-cycle windows, and each window holds a whole number of divider periods, so the expected delta is exact.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_FLAGS  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_RLD_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_RLD_HI = 3'd5;

  typedef struct packed {
    logic hi_fast;
    logic lo_fast;
    logic ext_sel;
    logic irq_en;
    logic lo_irq_en;
    logic split;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/split_timer_ticks.sv
module split_timer_ticks #(
  parameter int SLOW_DIV = 12,
  parameter int EXT_DIV  = 8,
  parameter int SYNC_N   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_i,
  output logic slow_tick_o,
  output logic ext_tick_o
);
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
  localparam logic [EW-1:0] EXT_LAST  = EW'(EXT_DIV - 1);

  logic [SW-1:0]     slow_q;
  logic [EW-1:0]     ext_q;
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              fall;

  // free-running system-clock divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  slow_q <= '0;
    else if (slow_q == SLOW_LAST) slow_q <= '0;
    else                          slow_q <= slow_q + 1'b1;
  end
  assign slow_tick_o = (slow_q == SLOW_LAST);

  // external clock synchronizer and falling-edge detector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], ext_clk_i};
      prev_q <= sync_q[SYNC_N-1];
    end
  end
  assign fall = prev_q & ~sync_q[SYNC_N-1];

  // count falling edges, pulse once per EXT_DIV of them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ext_q <= '0;
    else if (fall) ext_q <= (ext_q == EXT_LAST) ? '0 : ext_q + 1'b1;
  end
  assign ext_tick_o = fall & (ext_q == EXT_LAST);

endmodule

// File: rtl/split_timer_regs.sv
module split_timer_regs
  import split_timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              set_lo_i,
  input  logic              set_hi_i,
  output ctrl_t             cfg_o,
  output logic [BYTE_W-1:0] rld_lo_o,
  output logic [BYTE_W-1:0] rld_hi_o,
  output logic              wr_cnt_lo_o,
  output logic              wr_cnt_hi_o,
  output logic              flag_lo_o,
  output logic              flag_hi_o
);
  logic wr_flags;

  assign wr_flags    = wr_en_i & (wr_addr_i == ADR_FLAGS);
  assign wr_cnt_lo_o = wr_en_i & (wr_addr_i == ADR_CNT_LO);
  assign wr_cnt_hi_o = wr_en_i & (wr_addr_i == ADR_CNT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o    <= '0;
      rld_lo_o <= '0;
      rld_hi_o <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADR_CTRL:   cfg_o    <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        ADR_RLD_LO: rld_lo_o <= wr_data_i;
        ADR_RLD_HI: rld_hi_o <= wr_data_i;
        default: ;
      endcase
    end
  end

  // sticky flags: hardware set has priority over a software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_lo_o <= 1'b0;
      flag_hi_o <= 1'b0;
    end else begin
      if (set_lo_i)      flag_lo_o <= 1'b1;
      else if (wr_flags) flag_lo_o <= wr_data_i[0];
      if (set_hi_i)      flag_hi_o <= 1'b1;
      else if (wr_flags) flag_hi_o <= wr_data_i[1];
    end
  end

endmodule

// File: rtl/split_timer_core.sv
module split_timer_core #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              split_i,
  input  logic [1:0]        step_en_i,
  input  logic [BYTE_W-1:0] rld_lo_i,
  input  logic [BYTE_W-1:0] rld_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] cnt_lo_o,
  output logic [BYTE_W-1:0] cnt_hi_o,
  output logic              ovf_lo_o,
  output logic              ovf_hi_o
);
  localparam logic [BYTE_W-1:0] TOP = '1;

  logic step_lo, step_hi, lo_top, hi_top, carry;
  logic [BYTE_W-1:0] nxt_lo, nxt_hi;

  assign step_lo = run_i & step_en_i[0];
  assign step_hi = run_i & step_en_i[1];
  assign lo_top  = (cnt_lo_o == TOP);
  assign hi_top  = (cnt_hi_o == TOP);
  assign carry   = step_lo & lo_top;

  assign ovf_lo_o = carry;
  assign ovf_hi_o = split_i ? (step_hi & hi_top) : (carry & hi_top);

  always_comb begin
    nxt_lo = cnt_lo_o;
    if (step_lo) begin
      if (!lo_top)                nxt_lo = cnt_lo_o + 1'b1;
      else if (split_i || hi_top) nxt_lo = rld_lo_i;
      else                        nxt_lo = '0;
    end
  end

  always_comb begin
    nxt_hi = cnt_hi_o;
    if (split_i ? step_hi : carry) begin
      if (hi_top) nxt_hi = rld_hi_i;
      else        nxt_hi = cnt_hi_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo_o <= '0;
      cnt_hi_o <= '0;
    end else begin
      cnt_lo_o <= wr_lo_i ? wr_data_i : nxt_lo;
      cnt_hi_o <= wr_hi_i ? wr_data_i : nxt_hi;
    end
  end

endmodule

// File: rtl/split_timer.sv
module split_timer
  import split_timer_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SLOW_DIV = 12,
  parameter int EXT_DIV  = 8,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic              ovf_lo_o,
  output logic              ovf_hi_o,
  output logic              flag_lo_o,
  output logic              flag_hi_o,
  output logic              irq_o
);
  ctrl_t             cfg;
  logic [BYTE_W-1:0] rld_lo, rld_hi, cnt_lo, cnt_hi;
  logic [2*BYTE_W-1:0] rld;
  logic              wr_cnt_lo, wr_cnt_hi;
  logic              slow_tick, ext_tick, slow_src;
  logic [1:0]        fast_sel, byte_en, step_en;

  split_timer_ticks #(.SLOW_DIV(SLOW_DIV), .EXT_DIV(EXT_DIV), .SYNC_N(SYNC_N)) u_ticks (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i),
    .slow_tick_o(slow_tick), .ext_tick_o(ext_tick)
  );

  split_timer_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .set_lo_i(ovf_lo_o & cfg.split), .set_hi_i(ovf_hi_o),
    .cfg_o(cfg), .rld_lo_o(rld_lo), .rld_hi_o(rld_hi),
    .wr_cnt_lo_o(wr_cnt_lo), .wr_cnt_hi_o(wr_cnt_hi),
    .flag_lo_o(flag_lo_o), .flag_hi_o(flag_hi_o)
  );

  assign slow_src = cfg.ext_sel ? ext_tick : slow_tick;
  assign fast_sel = {cfg.hi_fast, cfg.lo_fast};

  for (genvar b = 0; b < 2; b++) begin : g_src
    assign byte_en[b] = fast_sel[b] | slow_src;
  end

  // in 16-bit mode the low byte's source paces the whole counter
  assign step_en = {cfg.split ? byte_en[1] : byte_en[0], byte_en[0]};

  split_timer_core #(.BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .run_i(cfg.run), .split_i(cfg.split), .step_en_i(step_en),
    .rld_lo_i(rld_lo), .rld_hi_i(rld_hi),
    .wr_lo_i(wr_cnt_lo), .wr_hi_i(wr_cnt_hi), .wr_data_i(wr_data_i),
    .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi),
    .ovf_lo_o(ovf_lo_o), .ovf_hi_o(ovf_hi_o)
  );

  assign cnt_o = {cnt_hi, cnt_lo};
  assign rld   = {rld_hi, rld_lo};
  assign irq_o = cfg.irq_en & (flag_hi_o | (cfg.lo_irq_en & flag_lo_o));

endmodule

// File: rtl/split_timer_checker.sv
module split_timer_checker
  import split_timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [2*BYTE_W-1:0] cnt_o,
  input logic [2*BYTE_W-1:0] rld,
  input logic                ovf_lo_o,
  input logic                ovf_hi_o,
  input logic                flag_lo_o,
  input logic                flag_hi_o,
  input logic                irq_o,
  input logic                run,
  input logic                split,
  input logic                irq_en
);
  logic cnt_wr, flag_wr;
  assign cnt_wr  = wr_en_i & ((wr_addr_i == ADR_CNT_LO) | (wr_addr_i == ADR_CNT_HI));
  assign flag_wr = wr_en_i & (wr_addr_i == ADR_FLAGS);

  p_full_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && ovf_hi_o && !cnt_wr) |=> (cnt_o == $past(rld)));

  p_hi_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hi_o |=> flag_hi_o);

  p_lo_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (split && ovf_lo_o) |=> flag_lo_o);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi_o && !flag_wr) |=> flag_hi_o);

  p_irq_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && flag_hi_o) |-> irq_o);

  p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt_o));

endmodule

bind split_timer split_timer_checker #(.BYTE_W(BYTE_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .cnt_o(cnt_o), .rld(rld), .ovf_lo_o(ovf_lo_o), .ovf_hi_o(ovf_hi_o),
  .flag_lo_o(flag_lo_o), .flag_hi_o(flag_hi_o), .irq_o(irq_o),
  .run(cfg.run), .split(cfg.split), .irq_en(cfg.irq_en)
);

// File: tb/test_split_timer.sv
module test_split_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cnt;
  logic        ovf_lo, ovf_hi, flag_lo, flag_hi, irq;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  split_timer i_split_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cnt_o(cnt), .ovf_lo_o(ovf_lo), .ovf_hi_o(ovf_hi),
    .flag_lo_o(flag_lo), .flag_hi_o(flag_hi), .irq_o(irq)
  );

  // external clock: period of 10 system cycles
  initial forever begin
    repeat (5) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands at the following posedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 reset cnt", cnt, 0);
    check("R6 reset flags", {flag_hi, flag_lo}, 0);
    check("R4 reset irq", irq, 0);
  endtask

  task automatic t_16bit;
    wr(3'd2, 8'hFD); wr(3'd3, 8'hFF); wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    wr(3'd0, 8'h29);               // run, irq_en, lo fast, 16-bit
    repeat (3) @(negedge clk);
    check("R1 full reload", cnt, 16'h1234);
    check("R1 only hi flag", {flag_hi, flag_lo}, 2'b10);
    check("R4 irq on hi flag", irq, 1);
    wr(3'd0, 8'h00);               // stop; counts once at this edge
    repeat (5) @(negedge clk);
    check("R9 held while stopped", cnt, 16'h1235);
    check("R6 flag sticky", flag_hi, 1);
    check("R4 irq off without enable", irq, 0);
    wr(3'd1, 8'h00);
    check("R6 write clears", {flag_hi, flag_lo}, 0);
    wr(3'd2, 8'hFE); wr(3'd3, 8'h00);
    wr(3'd0, 8'h21);
    repeat (3) @(negedge clk);
    check("R1 carry into high byte", cnt, 16'h0101);
    check("R1 no lo flag in 16-bit", flag_lo, 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_split;
    wr(3'd4, 8'hA0); wr(3'd5, 8'h50); wr(3'd2, 8'hFE); wr(3'd3, 8'hFD);
    wr(3'd0, 8'h6B);               // run, split, irq_en, both fast
    repeat (2) @(negedge clk);
    check("R2 lo reload", cnt, 16'hFFA0);
    check("R3 lo flag", {flag_hi, flag_lo}, 2'b01);
    check("R5 lo flag no irq without lo enable", irq, 0);
    @(negedge clk);
    check("R2 hi reload", cnt, 16'h50A1);
    check("R3 hi flag", flag_hi, 1);
    check("R4 irq", irq, 1);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    check("R6 both cleared", {flag_hi, flag_lo}, 0);
  endtask

  task automatic t_lo_irq;
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h2F);               // run, split, lo_irq_en, irq_en, lo fast
    check("R3 lo strobe before wrap", ovf_lo, 1);
    @(negedge clk);
    check("R2 lo reload again", cnt[7:0], 8'hA0);
    check("R5 irq from lo flag", irq, 1);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    check("R5 irq drops after clear", irq, 0);
  endtask

  task automatic t_collision;
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h23);               // run, split, lo fast, no irq
    wr(3'd1, 8'h00);               // clear write meets overflow
    check("R7 hw set wins", flag_lo, 1);
    check("R7 reload at same edge", cnt[7:0], 8'hA0);
    check("R4 no irq when disabled", irq, 0);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h02);
    check("R6 write sets hi flag", {flag_hi, flag_lo}, 2'b10);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_clk_sel;
    logic [15:0] a;
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h23);               // lo fast, hi on sys/12
    repeat (2) @(negedge clk);
    a = cnt;
    repeat (120) @(negedge clk);
    check("R8 lo fast rate", 32'(cnt[7:0] - a[7:0]), 120);
    check("R8 hi div12 rate", 32'(cnt[15:8] - a[15:8]), 10);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h13);               // ext select, split, both slow
    repeat (20) @(negedge clk);
    a = cnt;
    repeat (800) @(negedge clk);
    check("R8 lo ext rate", 32'(cnt[7:0] - a[7:0]), 10);
    check("R8 hi ext rate", 32'(cnt[15:8] - a[15:8]), 10);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_16bit();
    t_split();
    t_lo_irq();
    t_collision();
    t_clk_sel();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule